// File: doc/BRIEF.md
# Audio Serial Bit-Clock and Frame Generator

This block produces the serial bit clock, the channel-select line and the bit timing strobes that a master-mode stereo serial audio port needs. A counter divides the system clock by a programmable ratio. A five-state sequencer counts bit periods inside each channel half-frame and flips the channel-select line at the end of each half-frame. It can also stop the bit clock after a programmed number of bits in each half-frame. Transmit and receive shifters elsewhere use the one-cycle strobes to know when to shift or sample.

Software sets the divider value, the half-frame length code and the gating code, and then raises the generation enable. The three settings are captured only while generation is off, so changes made while it runs are ignored. A separate divider enable pauses the divider without losing position. Dropping the generation enable returns everything to idle.

Sequencer states: `SEQ_OFF` (idle), `SEQ_L_RUN` and `SEQ_L_GATE` (left half-frame, clock running or gated), `SEQ_R_RUN` and `SEQ_R_GATE` (right half-frame). The transitions are:
- OFF to L_RUN when the generation enable is seen high.
- L_RUN to L_GATE, or R_RUN to R_GATE, at the bit boundary after the last ungated bit.
- Any left state to R_RUN, and any right state to L_RUN, at the boundary after the last bit of the half-frame.
- Any state to OFF when the generation enable is low.

Top module: `audio_bitclk_gen`

## Requirements
- R1: While running, with P = div_val + 2, `bclk` has a period of P system cycles. It is low for floor(P/2) cycles and then high for the remaining cycles, so the duty cycle is uneven when P is odd.
- R2: `ws` is 0 during the left half-frame and 1 during the right half-frame. It changes every N bit periods, where half_code 0 gives N = 16, 1 gives 24, and 2 or 3 give 32.
- R3: gate_code 1, 2, 3 and 4 keep `bclk` active for the first 12, 16, 20 and 24 bits of each half-frame. In the remaining bits `bclk` stays low and no strobes are issued. Codes 0, 5, 6 and 7 disable gating.
- R4: `left_start` is a one-cycle pulse in the first cycle of every left half-frame. That covers the first half-frame after enable and every fall of `ws`. It never occurs while `ws` is 1.
- R5: `tx_bit_stb` pulses in the first cycle of every active bit, while `bclk` is low. `rx_bit_stb` pulses in the first cycle in which `bclk` is high.
- R6: When `gen_en` is sampled low, all five outputs are 0 from the next cycle. A later enable starts again at bit 0 of a left half-frame.
- R7: `div_val`, `half_code` and `gate_code` are captured while generation is off. Changes to them while generation is running have no effect on the outputs.
- R8: While `div_en` is 0 the divider holds its position: no `bclk` edges occur, no strobes are issued and `ws` does not change.
- R9: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_en | input | 1 | Clock generation enable |
| div_en | input | 1 | Divider run enable |
| div_val | input | 12 | Divide value, ratio 1/(div_val+2) |
| half_code | input | 2 | Half-frame length code |
| gate_code | input | 3 | Bit-clock gating code |
| bclk | output | 1 | Serial bit clock level |
| ws | output | 1 | Channel select, 0 = left |
| left_start | output | 1 | First cycle of a left half-frame |
| tx_bit_stb | output | 1 | Start of an active bit (shift out) |
| rx_bit_stb | output | 1 | Bit clock rising (sample in) |

## Verification
The bench predicts every output in every cycle from closed formulas for the phase within the bit, the bit within the half-frame and the half-frame parity. It compares those predictions against the design across these patterns:
- Even and odd divide ratios, which separate a correct duty split from an off-by-one high time.
- All three half-frame lengths, plus the code that aliases to 32.
- Each gating code, including a gate equal to the half-frame length and an out-of-range code. These show whether gating is counted from the start of each half-frame.

A run that changes the settings while running checks that they were captured at enable. A paused-divider run and a mid-right-half disable check freezing and return to idle.

// File: rtl/audclk_pkg.sv
package audclk_pkg;

    localparam int BIT_W = 6;

    typedef enum logic [2:0] {
        SEQ_OFF    = 3'd0,
        SEQ_L_RUN  = 3'd1,
        SEQ_L_GATE = 3'd2,
        SEQ_R_RUN  = 3'd3,
        SEQ_R_GATE = 3'd4
    } seq_state_e;

    // Bits per channel half-frame for a length code.
    function automatic logic [BIT_W-1:0] half_bits(input logic [1:0] code);
        unique case (code)
            2'd0:    half_bits = BIT_W'(16);
            2'd1:    half_bits = BIT_W'(24);
            default: half_bits = BIT_W'(32);
        endcase
    endfunction

    // Active bits per half-frame for a gating code; zero means no gating.
    function automatic logic [BIT_W-1:0] gate_bits(input logic [2:0] code);
        unique case (code)
            3'd1:    gate_bits = BIT_W'(12);
            3'd2:    gate_bits = BIT_W'(16);
            3'd3:    gate_bits = BIT_W'(20);
            3'd4:    gate_bits = BIT_W'(24);
            default: gate_bits = '0;
        endcase
    endfunction

endpackage

// File: rtl/audclk_divider.sv
module audclk_divider #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [DIV_W-1:0] div_val,
    output logic             rise_tick,
    output logic             fall_tick
);

    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] period_m1;
    logic [CNT_W-1:0] half_m1;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        period    = {1'b0, div_val} + CNT_W'(2);
        period_m1 = period - CNT_W'(1);
        half_m1   = (period >> 1) - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (advance) begin
            if (cnt == period_m1) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assign rise_tick = advance && !clear && (cnt == half_m1);
    assign fall_tick = advance && !clear && (cnt == period_m1);

endmodule

// File: rtl/audclk_sequencer.sv
module audclk_sequencer
    import audclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic             rise_tick,
    input  logic             fall_tick,
    input  logic [BIT_W-1:0] half_len,
    input  logic [BIT_W-1:0] gate_len,
    output logic             is_off,
    output logic             bclk,
    output logic             ws,
    output logic             left_start,
    output logic             tx_stb,
    output logic             rx_stb
);

    seq_state_e       state;
    seq_state_e       next_state;
    logic [BIT_W-1:0] bit_idx;
    logic             last_bit;
    logic             gate_hit;
    logic             cur_run;
    logic             nxt_run;
    logic             nxt_right;
    logic             cur_right;

    always_comb begin
        last_bit = (bit_idx == half_len - BIT_W'(1));
        gate_hit = (gate_len != '0) && (bit_idx + BIT_W'(1) == gate_len);
    end

    always_comb begin
        next_state = state;
        unique case (state)
            SEQ_OFF: begin
                if (gen_en) next_state = SEQ_L_RUN;
            end
            SEQ_L_RUN: begin
                if (fall_tick) begin
                    if (last_bit)      next_state = SEQ_R_RUN;
                    else if (gate_hit) next_state = SEQ_L_GATE;
                end
            end
            SEQ_L_GATE: begin
                if (fall_tick && last_bit) next_state = SEQ_R_RUN;
            end
            SEQ_R_RUN: begin
                if (fall_tick) begin
                    if (last_bit)      next_state = SEQ_L_RUN;
                    else if (gate_hit) next_state = SEQ_R_GATE;
                end
            end
            SEQ_R_GATE: begin
                if (fall_tick && last_bit) next_state = SEQ_L_RUN;
            end
            default: next_state = SEQ_OFF;
        endcase
        if (!gen_en) next_state = SEQ_OFF;
    end

    always_comb begin
        cur_run   = (state == SEQ_L_RUN) || (state == SEQ_R_RUN);
        cur_right = (state == SEQ_R_RUN) || (state == SEQ_R_GATE);
        nxt_run   = (next_state == SEQ_L_RUN) || (next_state == SEQ_R_RUN);
        nxt_right = (next_state == SEQ_R_RUN) || (next_state == SEQ_R_GATE);
    end

    // State register and bit position within the half-frame.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= SEQ_OFF;
            bit_idx <= '0;
        end else begin
            state <= next_state;
            if (next_state == SEQ_OFF || state == SEQ_OFF) begin
                bit_idx <= '0;
            end else if (fall_tick) begin
                bit_idx <= last_bit ? '0 : bit_idx + BIT_W'(1);
            end
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk       <= 1'b0;
            ws         <= 1'b0;
            left_start <= 1'b0;
            tx_stb     <= 1'b0;
            rx_stb     <= 1'b0;
        end else if (next_state == SEQ_OFF) begin
            bclk       <= 1'b0;
            ws         <= 1'b0;
            left_start <= 1'b0;
            tx_stb     <= 1'b0;
            rx_stb     <= 1'b0;
        end else begin
            ws         <= nxt_right;
            left_start <= (next_state == SEQ_L_RUN) &&
                          ((state == SEQ_OFF) || cur_right);
            tx_stb     <= (state == SEQ_OFF) || (fall_tick && nxt_run);
            rx_stb     <= rise_tick && cur_run;
            if (fall_tick || state == SEQ_OFF) begin
                bclk <= 1'b0;
            end else if (rise_tick && cur_run) begin
                bclk <= 1'b1;
            end
        end
    end

    assign is_off = (state == SEQ_OFF);

endmodule

// File: rtl/audio_bitclk_gen.sv
module audio_bitclk_gen
    import audclk_pkg::*;
#(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gen_en,
    input  logic             div_en,
    input  logic [DIV_W-1:0] div_val,
    input  logic [1:0]       half_code,
    input  logic [2:0]       gate_code,
    output logic             bclk,
    output logic             ws,
    output logic             left_start,
    output logic             tx_bit_stb,
    output logic             rx_bit_stb
);

    logic             seq_off;
    logic             rise_tick;
    logic             fall_tick;
    logic [DIV_W-1:0] cfg_div;
    logic [BIT_W-1:0] cfg_half;
    logic [BIT_W-1:0] cfg_gate;

    // Settings follow the inputs only while generation is idle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_div  <= '0;
            cfg_half <= half_bits(2'd0);
            cfg_gate <= '0;
        end else if (seq_off) begin
            cfg_div  <= div_val;
            cfg_half <= half_bits(half_code);
            cfg_gate <= gate_bits(gate_code);
        end
    end

    audclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (seq_off),
        .advance   (div_en),
        .div_val   (cfg_div),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    audclk_sequencer u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .gen_en     (gen_en),
        .rise_tick  (rise_tick),
        .fall_tick  (fall_tick),
        .half_len   (cfg_half),
        .gate_len   (cfg_gate),
        .is_off     (seq_off),
        .bclk       (bclk),
        .ws         (ws),
        .left_start (left_start),
        .tx_stb     (tx_bit_stb),
        .rx_stb     (rx_bit_stb)
    );

endmodule

// File: rtl/audclk_checker.sv
module audclk_checker (
    input logic clk,
    input logic rst_n,
    input logic gen_en,
    input logic div_en,
    input logic bclk,
    input logic ws,
    input logic left_start,
    input logic tx_bit_stb,
    input logic rx_bit_stb
);

    // R4
    ls_left_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        left_start |-> !ws);

    // R5
    rx_while_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bit_stb |-> bclk);

    // R5
    rise_has_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bclk) |-> rx_bit_stb);

    // R5
    tx_while_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_bit_stb |-> !bclk);

    // R2
    right_begins_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ws) |-> tx_bit_stb);

    // R6
    off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en |=> (!bclk && !ws && !left_start && !tx_bit_stb && !rx_bit_stb));

    // R8
    pause_no_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !div_en |=> !rx_bit_stb);

    // R8
    pause_ws_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!div_en && gen_en) |=> $stable(ws));

endmodule

bind audio_bitclk_gen audclk_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gen_en     (gen_en),
    .div_en     (div_en),
    .bclk       (bclk),
    .ws         (ws),
    .left_start (left_start),
    .tx_bit_stb (tx_bit_stb),
    .rx_bit_stb (rx_bit_stb)
);

// File: tb/audio_bitclk_gen_bench.sv
`timescale 1ns/1ps
module audio_bitclk_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gen_en = 1'b0;
    logic        div_en = 1'b1;
    logic [11:0] div_val = '0;
    logic [1:0]  half_code = '0;
    logic [2:0]  gate_code = '0;
    logic        bclk, ws, left_start, tx_bit_stb, rx_bit_stb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int         t;
        logic [4:0] v;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #10 clk = ~clk;

    audio_bitclk_gen u_audio_bitclk_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .gen_en     (gen_en),
        .div_en     (div_en),
        .div_val    (div_val),
        .half_code  (half_code),
        .gate_code  (gate_code),
        .bclk       (bclk),
        .ws         (ws),
        .left_start (left_start),
        .tx_bit_stb (tx_bit_stb),
        .rx_bit_stb (rx_bit_stb)
    );

    // Expected {bclk, ws, left_start, tx, rx} at t cycles after the enabling edge.
    function automatic logic [4:0] model(int t, int p, int n, int g);
        int ph, b, hf, j, h;
        logic act;
        ph  = t % p;
        b   = t / p;
        hf  = b / n;
        j   = b % n;
        h   = p / 2;
        act = (g == 0) || (j < g);
        model = {act && (ph >= h), hf % 2 == 1,
                 ph == 0 && j == 0 && hf % 2 == 0,
                 act && ph == 0, act && ph == h};
    endfunction

    function automatic string field_req(logic [4:0] d);
        if (d[4])      field_req = "R1/R3 bclk";
        else if (d[3]) field_req = "R2 ws";
        else if (d[2]) field_req = "R4 left_start";
        else           field_req = "R5 strobe";
    endfunction

    // Monitor: pops one expected item per cycle and compares.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            logic [4:0] got;
            e = exp_q.pop_front();
            got = {bclk, ws, left_start, tx_bit_stb, rx_bit_stb};
            checks++;
            if (got !== e.v) begin
                errors++;
                $display("FAIL %s (%s) t=%0d got=%b exp=%b", e.tag,
                         field_req(got ^ e.v), e.t, got, e.v);
            end
        end
    end

    task automatic check_idle(string tag);
        checks++;
        if ({bclk, ws, left_start, tx_bit_stb, rx_bit_stb} !== 5'b0) begin
            errors++;
            $display("FAIL %s idle got=%b exp=00000", tag,
                     {bclk, ws, left_start, tx_bit_stb, rx_bit_stb});
        end
    endtask

    // Driver: enable with settings, push predicted outputs, optionally disturb settings.
    task automatic run_case(int dv, int hc, int gc, int n, int g, int cycles,
                            bit mid_change, string tag);
        @(negedge clk);
        div_val   = 12'(dv);
        half_code = 2'(hc);
        gate_code = 3'(gc);
        gen_en    = 1'b1;
        @(posedge clk);
        #1;
        for (int t = 0; t < cycles; t++) begin
            exp_t e;
            e.t = t;
            e.v = model(t, dv + 2, n, g);
            e.tag = tag;
            exp_q.push_back(e);
        end
        if (mid_change) begin
            repeat (5) @(negedge clk);
            #1;
            div_val   = 12'd0;
            half_code = 2'd2;
            gate_code = 3'd1;
        end
        wait (exp_q.size() == 0);
        @(negedge clk);
        gen_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // R6 outputs idle one cycle after disable
        check_idle("R6");
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check_idle("R9");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 even ratio, R2 16-bit halves
        run_case(0, 0, 0, 16, 0, 128, 1'b0, "R1");
        // R1 odd ratio, R3 gate after 12 bits, R2 24-bit halves
        run_case(1, 1, 1, 24, 12, 288, 1'b0, "R3");
        // R3 gate after 20 bits
        run_case(0, 1, 3, 24, 20, 192, 1'b0, "R3");
        // R3 gate after 24 bits, R2 32-bit halves
        run_case(2, 2, 4, 32, 24, 512, 1'b0, "R2");
        // R2 code 3 aliases to 32, R3 out-of-range gate code means no gating
        run_case(0, 3, 6, 32, 0, 256, 1'b0, "R2");
        // R7 settings changed mid-run are ignored; R6 disable while ws=1
        run_case(3, 0, 2, 16, 16, 90, 1'b1, "R7");
        // R4 left_start at re-enable after mid-frame disable, R5 strobes
        run_case(0, 0, 0, 16, 0, 70, 1'b0, "R4");

        // R8 divider paused: only the entry strobes, nothing else
        @(negedge clk);
        div_en    = 1'b0;
        div_val   = 12'd0;
        half_code = 2'd0;
        gate_code = 3'd0;
        gen_en    = 1'b1;
        @(posedge clk);
        #1;
        for (int t = 0; t < 20; t++) begin
            exp_t e;
            e.t = t;
            e.v = (t == 0) ? 5'b00110 : 5'b00000;
            e.tag = "R8";
            exp_q.push_back(e);
        end
        wait (exp_q.size() == 0);
        @(negedge clk);
        gen_en = 1'b0;
        div_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_idle("R6");

        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule